// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects fourteen interrupt requests and picks one to hand to a processor core. The requests are a filtered edge-triggered non-maskable line, five level-sensitive external lines, four level-sensitive stack-fault lines, three edge-triggered timer events and one software-set request. It removes the requests that are masked in a software-written mask register, selects the highest-priority survivor, and forms a vector address. The address is a fixed five-bit priority code joined to base bits from a software-written base register. Each handler entry therefore starts on a 32-byte boundary in page zero.

The vector register is held while the acknowledge input is high. It is also not recomputed in the cycle that follows the acknowledge's falling edge. This keeps the address seen by the memory cycle stable. Software can read the vector through a single-cycle register port at any time. When nothing is pending, the vector carries a distinct code with bit 9 set. The same port writes the mask and base registers and sets or clears the software request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The selected source is the pending, unmasked one with the lowest priority index. Index 0 is the non-maskable line `nmi_in`. Index 1 is `ext_irq[0]`. Indices 2 to 5 are `stk_fault[0..3]`. Index 6 is `ext_irq[1]`. Indices 7 to 9 are the timer events `tmr_evt[0..2]`. Indices 10 to 12 are `ext_irq[2..4]`. Index 13 is the software request. Vector bits [9:5] hold the code 15 minus the index.
- R2: When mask register bit n (n from 1 to 13) is 1, source index n is ignored. The non-maskable source cannot be masked, and `irq_pending` is 1 whenever any unmasked source is pending.
- R3: After reset, the mask and base registers read 0, no request is latched, `irq_pending` is 0 and `ack_addr` is 20'h00200.
- R4: `ack_addr[19:16]` and `ack_addr[4:0]` are always 0, and `ack_addr[15:10]` equals base register bits [15:10]. With no unmasked request pending, bits [9:5] are 5'b10000.
- R5: The vector does not change in any cycle where `inta` is high. It also does not change in the first cycle after `inta` falls. It follows the requests again one cycle later.
- R6: A rising edge on a timer input sets a sticky request that stays after the input falls. The request clears when `inta` falls while the held vector carries that timer's code. A held vector for another source leaves the request set.
- R7: The non-maskable line requests only after it rises and stays high for two consecutive clock samples. A one-sample pulse is ignored. A level held high does not re-request after its acknowledge completes, because the acknowledge clears the latched request.
- R8: Writing `reg_sel`=3 sets the software request to `reg_wdata[0]`. Reading `reg_sel`=3 returns that request in bit 0.
- R9: Reading `reg_sel`=2 returns `ack_addr[15:0]`. Writing `reg_sel`=0 sets the mask register and writing `reg_sel`=1 sets the base register; both read back unchanged. Level-sensitive sources drop out of the vector once their input goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, rising edge with filter |
| ext_irq | input | 5 | External level requests |
| stk_fault | input | 4 | Stack fault level requests |
| tmr_evt | input | 3 | Timer event inputs, rising edge |
| inta | input | 1 | Interrupt acknowledge, high during the acknowledge cycle |
| reg_sel | input | 2 | Register select: 0 mask, 1 base, 2 vector, 3 software request |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq_pending | output | 1 | Any unmasked request is pending |
| ack_addr | output | 20 | Vector address for the acknowledge cycle |

## Verification
Random level patterns on the external and stack lines, with random masks, base values and software requests, check priority order and masking against an independently written priority model. Directed timer pulses, including two timers at once, show sticky capture and clearing by vector match. A short and a long non-maskable pulse, tried under a full mask, separate the glitch filter from edge latching and unmaskability. An acknowledge during which the requests change shows the hold across both acknowledge edges.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_SRC  = 14;
  localparam int NUM_EXT  = 5;
  localparam int NUM_STK  = 4;
  localparam int NUM_TMR  = 3;
  localparam int DATA_W   = 16;
  localparam int CODE_W   = 5;
  localparam int ADDR_W   = 20;
  localparam int TMR_BASE_IDX = 7;
  localparam logic [CODE_W-1:0] CODE_NONE = 5'b10000;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_BASE = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_SWI  = 2'd3
  } reg_sel_e;

  // code for priority index p: highest priority gets 15
  function automatic logic [CODE_W-1:0] prio_code(input int unsigned p);
    return CODE_W'(15 - p);
  endfunction

  function automatic logic [DATA_W-1:0] make_vector(input logic [DATA_W-1:0] base,
                                                    input logic [CODE_W-1:0] code);
    return {base[15:10], code, 5'b00000};
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_vec_pkg::*;
#(
  parameter int NMI_FILT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nmi_in,
  input  logic [NUM_EXT-1:0]   ext_irq,
  input  logic [NUM_STK-1:0]   stk_fault,
  input  logic [NUM_TMR-1:0]   tmr_evt,
  input  logic                 swi_wr,
  input  logic                 swi_val,
  input  logic                 ack_done,
  input  logic [CODE_W-1:0]    ack_code,
  output logic [NUM_SRC-1:0]   req_raw,
  output logic                 nmi_flag,
  output logic [NUM_TMR-1:0]   tmr_flag,
  output logic                 swi_flag
);
  localparam int HIST_W = NMI_FILT + 1;

  logic [HIST_W-1:0]  nmi_hist;
  logic               nmi_rise;
  logic [NUM_TMR-1:0] tmr_q;
  logic [NUM_TMR-1:0] tmr_rise;

  // shift register glitch filter on the non-maskable line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_hist <= '0;
    else        nmi_hist <= {nmi_hist[HIST_W-2:0], nmi_in};
  end

  assign nmi_rise = (&nmi_hist[NMI_FILT-1:0]) & ~nmi_hist[NMI_FILT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_flag <= 1'b0;
    else if (nmi_rise) nmi_flag <= 1'b1;
    else if (ack_done && ack_code == prio_code(0)) nmi_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_evt;
  end

  assign tmr_rise = tmr_evt & ~tmr_q;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_flag[i] <= 1'b0;
      else if (tmr_rise[i]) tmr_flag[i] <= 1'b1;
      else if (ack_done && ack_code == prio_code(TMR_BASE_IDX + i)) tmr_flag[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      swi_flag <= 1'b0;
    else if (swi_wr) swi_flag <= swi_val;
  end

  // request vector in priority order, index 0 highest
  always_comb begin
    req_raw      = '0;
    req_raw[0]   = nmi_flag;
    req_raw[1]   = ext_irq[0];
    req_raw[5:2] = stk_fault;
    req_raw[6]   = ext_irq[1];
    req_raw[9:7] = tmr_flag;
    req_raw[12:10] = ext_irq[4:2];
    req_raw[13]  = swi_flag;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_vec_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_raw,
  input  logic [DATA_W-1:0]  mask,
  output logic [NUM_SRC-1:0] req_eff,
  output logic [CODE_W-1:0]  sel_code,
  output logic               any_req
);
  logic [NUM_SRC-1:0] mask_eff;

  // index 0 has no mask bit
  assign mask_eff = {mask[NUM_SRC-1:1], 1'b0};
  assign req_eff  = req_raw & ~mask_eff;
  assign any_req  = |req_eff;

  always_comb begin
    sel_code = CODE_NONE;
    for (int p = NUM_SRC - 1; p >= 0; p--) begin
      if (req_eff[p]) sel_code = prio_code(p);
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] vec_q,
  input  logic              swi_flag,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] base_q,
  output logic              swi_wr,
  output logic              swi_val,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_MASK) mask_q <= reg_wdata;
      if (sel == SEL_BASE) base_q <= reg_wdata;
    end
  end

  assign swi_wr  = reg_wr && (sel == SEL_SWI);
  assign swi_val = reg_wdata[0];

  always_comb begin
    unique case (sel)
      SEL_MASK: reg_rdata = mask_q;
      SEL_BASE: reg_rdata = base_q;
      SEL_VEC:  reg_rdata = vec_q;
      SEL_SWI:  reg_rdata = {{(DATA_W-1){1'b0}}, swi_flag};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NMI_FILT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nmi_in,
  input  logic [NUM_EXT-1:0]  ext_irq,
  input  logic [NUM_STK-1:0]  stk_fault,
  input  logic [NUM_TMR-1:0]  tmr_evt,
  input  logic                inta,
  input  logic [1:0]          reg_sel,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_pending,
  output logic [ADDR_W-1:0]   ack_addr
);
  logic [NUM_SRC-1:0] req_raw;
  logic [NUM_SRC-1:0] req_eff;
  logic [CODE_W-1:0]  sel_code;
  logic               nmi_flag;
  logic [NUM_TMR-1:0] tmr_flag;
  logic               swi_flag;
  logic               swi_wr;
  logic               swi_val;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  base_q;
  logic [DATA_W-1:0]  vec_q;
  logic               inta_q;
  logic               vec_upd;
  logic               ack_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inta_q <= 1'b0;
    else        inta_q <= inta;
  end

  // recompute only when acknowledge is low now and was low last cycle
  assign vec_upd  = ~inta & ~inta_q;
  assign ack_done = inta_q & ~inta;

  irq_capture #(.NMI_FILT(NMI_FILT)) u_cap (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .ext_irq(ext_irq),
    .stk_fault(stk_fault), .tmr_evt(tmr_evt), .swi_wr(swi_wr),
    .swi_val(swi_val), .ack_done(ack_done), .ack_code(vec_q[9:5]),
    .req_raw(req_raw), .nmi_flag(nmi_flag), .tmr_flag(tmr_flag),
    .swi_flag(swi_flag)
  );

  irq_prio_sel u_sel (
    .req_raw(req_raw), .mask(mask_q), .req_eff(req_eff),
    .sel_code(sel_code), .any_req(irq_pending)
  );

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .vec_q(vec_q), .swi_flag(swi_flag),
    .mask_q(mask_q), .base_q(base_q), .swi_wr(swi_wr), .swi_val(swi_val),
    .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vec_q <= make_vector('0, CODE_NONE);
    else if (vec_upd) vec_q <= make_vector(base_q, sel_code);
  end

  assign ack_addr = {4'h0, vec_q};
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_vec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               inta,
  input logic [ADDR_W-1:0]  ack_addr,
  input logic               irq_pending,
  input logic               nmi_flag,
  input logic [NUM_TMR-1:0] tmr_flag,
  input logic               ack_done,
  input logic [DATA_W-1:0]  mask_q,
  input logic               reg_wr,
  input logic [1:0]         reg_sel,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               swi_flag
);
  assert_hold_during_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inta) || $past(inta, 2)) |-> $stable(ack_addr));

  assert_fixed_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_addr[19:16] == 4'h0) && (ack_addr[4:0] == 5'h0));

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_addr[9:5] == CODE_NONE) || (ack_addr[9:5] >= 5'd2 && ack_addr[9:5] <= 5'd15));

  assert_nmi_unmaskable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_flag |-> irq_pending);

  assert_mask_cleared_R3: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_sticky
    assert_timer_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_flag[i] && !ack_done) |=> tmr_flag[i]);
  end

  assert_swi_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3) |=> (swi_flag == $past(reg_wdata[0])));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (.*);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_in = 1'b0;
  logic [4:0]  ext_irq = '0;
  logic [3:0]  stk_fault = '0;
  logic [2:0]  tmr_evt = '0;
  logic        inta = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_pending;
  logic [19:0] ack_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .ext_irq(ext_irq),
    .stk_fault(stk_fault), .tmr_evt(tmr_evt), .inta(inta),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pending(irq_pending), .ack_addr(ack_addr)
  );

  // bench model: list of request bits by priority, first set one wins
  function automatic logic [19:0] exp_vec(input logic nmi, input logic [4:0] e,
      input logic [3:0] s, input logic [2:0] t, input logic swi,
      input logic [15:0] m, input logic [15:0] b);
    logic [13:0] lst;
    logic [4:0] code;
    lst = {swi, e[4], e[3], e[2], t[2], t[1], t[0], e[1], s[3], s[2], s[1], s[0], e[0], nmi};
    lst[13:1] = lst[13:1] & ~m[13:1];
    code = 5'b10000;
    for (int k = 0; k < 14; k++) begin
      if (lst[k] && code == 5'b10000) code = 5'd15 - 5'(k);
    end
    return {4'h0, b[15:10], code, 5'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); inta = 1'b1;
    settle(2);
    inta = 1'b0;
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    logic [15:0] d, m, b;
    logic swi;
    void'($urandom(seed));
    settle(3);
    // R3 reset state
    check("R3 addr", 32'(ack_addr), 32'h00200);
    check("R3 pend", 32'(irq_pending), 0);
    rd(2'd0, d); check("R3 mask", 32'(d), 0);
    rd(2'd1, d); check("R3 base", 32'(d), 0);
    @(negedge clk); rst_n = 1'b1;
    settle(2);
    check("R4 none code", 32'(ack_addr), 32'h00200);

    // R1 R2 R4 R9 random levels
    for (int it = 0; it < 60; it++) begin
      m = 16'($urandom()) & 16'h3FFE;
      if (it % 3 == 0) m = 16'h0;
      b = 16'($urandom());
      swi = 1'($urandom());
      wr(2'd0, m);
      wr(2'd1, b);
      wr(2'd3, {15'h0, swi});
      @(negedge clk);
      ext_irq = 5'($urandom()); stk_fault = 4'($urandom());
      if (it % 4 == 0) begin ext_irq = '0; stk_fault = '0; end
      settle(3);
      check("R1 R2 R4 priority vector", 32'(ack_addr),
            32'(exp_vec(1'b0, ext_irq, stk_fault, 3'b0, swi, m, b)));
      check("R2 pending", 32'(irq_pending),
            32'(exp_vec(1'b0, ext_irq, stk_fault, 3'b0, swi, m, b)[9:5] != 5'b10000));
      rd(2'd2, d); check("R9 vector read", 32'(d), 32'(ack_addr[15:0]));
      rd(2'd0, d); check("R9 mask read", 32'(d), 32'(m));
      rd(2'd1, d); check("R9 base read", 32'(d), 32'(b));
      rd(2'd3, d); check("R8 swi read", 32'(d), 32'(swi));
    end
    @(negedge clk); ext_irq = '0; stk_fault = '0;
    wr(2'd3, 16'h0); wr(2'd0, 16'h0); wr(2'd1, 16'h0);
    settle(3);
    check("R9 level drop", 32'(ack_addr), 32'h00200);

    // R8 software request alone: code 2
    wr(2'd3, 16'h1); settle(2);
    check("R8 swi set", 32'(ack_addr), 32'h00040);
    wr(2'd3, 16'h0); settle(2);
    check("R8 swi clear", 32'(ack_addr), 32'h00200);

    // R5 hold across acknowledge
    @(negedge clk); ext_irq = 5'b00001; settle(3);
    check("R5 pre", 32'(ack_addr), 32'h001C0);
    inta = 1'b1; settle(1);
    ext_irq = 5'b00010; settle(3);
    check("R5 held high", 32'(ack_addr), 32'h001C0);
    inta = 1'b0; settle(1);
    check("R5 held after fall", 32'(ack_addr), 32'h001C0);
    settle(1);
    check("R5 resumes", 32'(ack_addr), 32'h00120);
    ext_irq = '0; settle(3);

    // R6 timer sticky
    tmr_evt = 3'b010; settle(3);
    check("R6 timer1", 32'(ack_addr), 32'h000E0);
    tmr_evt = 3'b000; settle(3);
    check("R6 sticky", 32'(ack_addr), 32'h000E0);
    do_ack(); settle(3);
    check("R6 cleared", 32'(ack_addr), 32'h00200);
    tmr_evt = 3'b101; settle(1); tmr_evt = 3'b000; settle(3);
    check("R6 two timers", 32'(ack_addr), 32'h00100);
    do_ack(); settle(3);
    check("R6 other kept", 32'(ack_addr), 32'h000C0);
    do_ack(); settle(3);
    check("R6 last cleared", 32'(ack_addr), 32'h00200);

    // R7 NMI filter, unmaskable under full mask
    wr(2'd0, 16'hFFFF);
    @(negedge clk); nmi_in = 1'b1; settle(1); nmi_in = 1'b0; settle(5);
    check("R7 short pulse ignored", 32'(ack_addr), 32'h00200);
    nmi_in = 1'b1; settle(4);
    check("R7 R2 nmi", 32'(ack_addr), 32'h001E0);
    check("R2 nmi pending", 32'(irq_pending), 1);
    do_ack(); settle(4);
    check("R7 held level no rerequest", 32'(ack_addr), 32'h00200);
    nmi_in = 1'b0; settle(2);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule